// File: doc/BRIEF.md
# PLL Dynamic Phase-Shift Sequencer

This block sits in the fabric beside a PLL that can shift its output phase at run time. A user asks for one phase action at a time. A request names the target output channel, the direction, and the kind of action. The action is either a run of VCO-phase steps of 45 degrees each, or a single post-divider phase reload. The block turns that request into the PLL's control handshake. It drives a two-bit output select and a direction bit. It drives an active-low step strobe or an active-high load strobe. It reports whether it is busy and when it is done.

The PLL acts on the falling edge of either strobe. Select and direction must therefore settle before that edge. Each strobe must also keep its high and low levels for minimum times, given either in nanoseconds or in VCO periods. The block turns every such limit into a whole number of fabric clock cycles. Each count is the limit divided by the fabric clock period, rounded up, and never less than one cycle. The limits themselves come from parameters given in picoseconds.

A request is taken only while the block is idle. The block then works through these phases in order: setup, strobe active, strobe released, settle, and a one-cycle done. One step request may ask for several consecutive 45-degree steps. The minimum high time is kept between successive step pulses.

Top module: `pll_phase_seq`

## Requirements
- R1: After reset, and at any time the block is not busy, `pll_step_n` is 1, `pll_load` is 0, `busy` is 0 and `done` is 0.
- R2: A request (`req_valid` = 1) is accepted only while `busy` is 0. A request raised while busy is ignored: it adds no strobe pulse, does not change select or direction, and does not start a new operation after `done`.
- R3: From the cycle `busy` rises until it falls, `pll_sel` and `pll_dir` hold the values of `req_sel` and `req_dir` taken at acceptance. `pll_dir` = 0 means a delayed (lagging) shift and 1 means an advanced (leading) shift. `pll_sel` codes 0 to 3 pick the main output and the three secondary outputs.
- R4: After `busy` rises, both strobes stay at rest for exactly SETUP_N = max(1, ceil(SETUP_PS / CLK_PS)) cycles before the first strobe becomes active.
- R5: Each step pulse drives `pll_step_n` low for exactly STEP_N = max(1, ceil(VCO_MIN_CYC × VCO_PS / CLK_PS)) cycles.
- R6: Between two consecutive step pulses of one request, `pll_step_n` stays high for exactly STEP_N cycles.
- R7: A step request (`req_load` = 0) produces `req_count` step pulses. A count of 0 produces one pulse.
- R8: A load request (`req_load` = 1) produces exactly one `pll_load` pulse lasting LOAD_N = max(1, ceil(LOAD_PS / CLK_PS)) cycles. It produces no step pulse, and `req_count` has no effect on it. The two strobes are never active at the same time.
- R9: After the last strobe returns to rest, the block waits exactly STEP_N + SETTLE_N cycles, with SETTLE_N = max(1, ceil(SETTLE_VCO × VCO_PS / CLK_PS)). `done` then rises while `busy` is still 1.
- R10: `done` is high for exactly one cycle. In the cycle after it, `busy` is 0 and a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_load | input | 1 | 0 = VCO step run, 1 = post-divider reload |
| req_sel | input | 2 | Target output channel code 0 to 3 |
| req_dir | input | 1 | 0 = lag, 1 = lead |
| req_count | input | REP_W | Number of steps (0 acts as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pll_sel | output | 2 | Output select to the PLL |
| pll_dir | output | 1 | Direction to the PLL |
| pll_step_n | output | 1 | Active-low VCO step strobe |
| pll_load | output | 1 | Active-high post-divider load strobe |

## Verification
The assertions assume that reset is held at time zero and for at least one clock edge. This puts every output at its rest level before any check applies. They also assume that no count fits outside the counter widths. The bench sets the timing parameters so that SETUP_N, STEP_N, LOAD_N and SETTLE_N are all larger than one, which makes off-by-one errors visible. It drives requests only between clock edges and waits for `busy` to fall before each accepted request. The one exception is a deliberate request raised mid-operation with a different select and direction, used to check that such a request is ignored.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ASSERT,
        ST_RELEASE,
        ST_SETTLE,
        ST_DONE
    } pps_state_e;

    typedef enum logic {
        ACT_STEP = 1'b0,
        ACT_LOAD = 1'b1
    } pps_action_e;

    typedef struct packed {
        pps_action_e action;
        logic [1:0]  sel;
        logic        dir;
    } pps_req_t;

    // Cycles needed to cover span_ps with clock period clk_ps, at least one.
    function automatic int unsigned cyc_ceil(input int unsigned span_ps,
                                             input int unsigned clk_ps);
        int unsigned r;
        r = (span_ps + clk_ps - 1) / clk_ps;
        if (r < 1) r = 1;
        return r;
    endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // A loaded value v makes expired rise in the v-th cycle after the load.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
    import pps_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned REP_W    = 4,
    parameter int unsigned SETUP_N  = 1,
    parameter int unsigned STEP_N   = 1,
    parameter int unsigned LOAD_N   = 1,
    parameter int unsigned SETTLE_N = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  pps_req_t         req_in,
    input  logic [REP_W-1:0] req_count,
    input  logic             tmr_expired,
    output pps_state_e       state_q,
    output pps_state_e       state_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pps_req_t         req_q
);
    localparam logic [CNT_W-1:0] SETUP_C  = CNT_W'(SETUP_N);
    localparam logic [CNT_W-1:0] STEP_C   = CNT_W'(STEP_N);
    localparam logic [CNT_W-1:0] LOAD_C   = CNT_W'(LOAD_N);
    localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE_N);
    localparam logic [REP_W-1:0] ONE_REP  = REP_W'(1);

    logic [REP_W-1:0] rem_q;
    logic             accept;
    logic             more_steps;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign more_steps = (req_q.action == ACT_STEP) && (rem_q > ONE_REP);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = SETUP_C;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_C;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_ASSERT;
                    tmr_load = 1'b1;
                    tmr_val  = (req_q.action == ACT_LOAD) ? LOAD_C : STEP_C;
                end
            end
            ST_ASSERT: begin
                if (tmr_expired) begin
                    state_d  = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = STEP_C;
                end
            end
            ST_RELEASE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (more_steps) begin
                        state_d = ST_ASSERT;
                        tmr_val = STEP_C;
                    end else begin
                        state_d = ST_SETTLE;
                        tmr_val = SETTLE_C;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q <= req_in;
                rem_q <= (req_count == '0) ? ONE_REP : req_count;
            end else if (state_q == ST_RELEASE && tmr_expired && more_steps) begin
                rem_q <= rem_q - ONE_REP;
            end
        end
    end
endmodule

// File: rtl/pps_drive.sv
module pps_drive
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pps_state_e state_d,
    input  pps_req_t   req_q,
    output logic       busy,
    output logic       done,
    output logic [1:0] pll_sel,
    output logic       pll_dir,
    output logic       pll_step_n,
    output logic       pll_load
);
    logic strobe_on;
    assign strobe_on = (state_d == ST_ASSERT);

    // All strobes and flags come from flops fed by the next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            pll_step_n <= 1'b1;
            pll_load   <= 1'b0;
        end else begin
            busy       <= (state_d != ST_IDLE);
            done       <= (state_d == ST_DONE);
            pll_step_n <= !(strobe_on && req_q.action == ACT_STEP);
            pll_load   <= strobe_on && (req_q.action == ACT_LOAD);
        end
    end

    assign pll_sel = req_q.sel;
    assign pll_dir = req_q.dir;
endmodule

// File: rtl/pll_phase_seq.sv
module pll_phase_seq
    import pps_pkg::*;
#(
    parameter int unsigned CLK_PS      = 10000,
    parameter int unsigned VCO_PS      = 1600,
    parameter int unsigned SETUP_PS    = 5000,
    parameter int unsigned LOAD_PS     = 10000,
    parameter int unsigned VCO_MIN_CYC = 4,
    parameter int unsigned SETTLE_VCO  = 4,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned REP_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_load,
    input  logic [1:0]       req_sel,
    input  logic             req_dir,
    input  logic [REP_W-1:0] req_count,
    output logic             busy,
    output logic             done,
    output logic [1:0]       pll_sel,
    output logic             pll_dir,
    output logic             pll_step_n,
    output logic             pll_load
);
    localparam int unsigned SETUP_N  = cyc_ceil(SETUP_PS, CLK_PS);
    localparam int unsigned STEP_N   = cyc_ceil(VCO_MIN_CYC * VCO_PS, CLK_PS);
    localparam int unsigned LOAD_N   = cyc_ceil(LOAD_PS, CLK_PS);
    localparam int unsigned SETTLE_N = cyc_ceil(SETTLE_VCO * VCO_PS, CLK_PS);

    pps_state_e       state_q, state_d;
    pps_req_t         req_in, req_q;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    assign req_in.action = req_load ? ACT_LOAD : ACT_STEP;
    assign req_in.sel    = req_sel;
    assign req_in.dir    = req_dir;

    pps_ctrl #(
        .CNT_W   (CNT_W),
        .REP_W   (REP_W),
        .SETUP_N (SETUP_N),
        .STEP_N  (STEP_N),
        .LOAD_N  (LOAD_N),
        .SETTLE_N(SETTLE_N)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .req_count  (req_count),
        .tmr_expired(tmr_expired),
        .state_q    (state_q),
        .state_d    (state_d),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .req_q      (req_q)
    );

    pps_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    pps_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .state_d   (state_d),
        .req_q     (req_q),
        .busy      (busy),
        .done      (done),
        .pll_sel   (pll_sel),
        .pll_dir   (pll_dir),
        .pll_step_n(pll_step_n),
        .pll_load  (pll_load)
    );
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
    parameter int unsigned STEP_N = 1,
    parameter int unsigned LOAD_N = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic [1:0] pll_sel,
    input logic       pll_dir,
    input logic       pll_step_n,
    input logic       pll_load
);
    logic [15:0] low_run, high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            if (!pll_step_n) low_run <= (low_run == 16'hFFFF) ? low_run : low_run + 16'd1;
            else             low_run <= '0;
            if (pll_load)    high_run <= (high_run == 16'hFFFF) ? high_run : high_run + 16'd1;
            else             high_run <= '0;
        end
    end

    p_rest_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pll_step_n && !pll_load));

    p_hold_sel_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(pll_sel) && $stable(pll_dir)));

    p_step_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_step_n) |-> (low_run == 16'(STEP_N)));

    p_load_width_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_load) |-> (high_run == 16'(LOAD_N)));

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        pll_load |-> pll_step_n);

    p_done_rest_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && pll_step_n && !pll_load));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind pll_phase_seq pps_chk #(.STEP_N(STEP_N), .LOAD_N(LOAD_N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .pll_sel   (pll_sel),
    .pll_dir   (pll_dir),
    .pll_step_n(pll_step_n),
    .pll_load  (pll_load)
);

// File: tb/sim_pll_phase_seq.sv
`timescale 1ns/1ps
module sim_pll_phase_seq;
    localparam int CLK_PS = 10000, VCO_PS = 6000, SETUP_PS = 15000;
    localparam int LOAD_PS = 25000, VCO_MIN = 4, SETTLE_V = 4, REP_W = 4;

    function automatic int cdiv(input int a, input int b);
        int r;
        r = (a + b - 1) / b;
        return (r < 1) ? 1 : r;
    endfunction

    localparam int E_SETUP  = cdiv(SETUP_PS, CLK_PS);
    localparam int E_STEP   = cdiv(VCO_MIN * VCO_PS, CLK_PS);
    localparam int E_LOAD   = cdiv(LOAD_PS, CLK_PS);
    localparam int E_SETTLE = cdiv(SETTLE_V * VCO_PS, CLK_PS);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_load = 1'b0, req_dir = 1'b0;
    logic [1:0] req_sel = '0;
    logic [REP_W-1:0] req_count = '0;
    logic busy, done, pll_dir, pll_step_n, pll_load;
    logic [1:0] pll_sel;

    always #5 clk = ~clk;

    pll_phase_seq #(
        .CLK_PS(CLK_PS), .VCO_PS(VCO_PS), .SETUP_PS(SETUP_PS), .LOAD_PS(LOAD_PS),
        .VCO_MIN_CYC(VCO_MIN), .SETTLE_VCO(SETTLE_V), .CNT_W(8), .REP_W(REP_W)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_load(req_load),
        .req_sel(req_sel), .req_dir(req_dir), .req_count(req_count),
        .busy(busy), .done(done), .pll_sel(pll_sel), .pll_dir(pll_dir),
        .pll_step_n(pll_step_n), .pll_load(pll_load)
    );

    typedef struct {
        int kind; int sel; int dir; int steps; int loads;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: waits for idle, raises one request, pushes the expected outcome.
    task automatic issue(input int kind, input int sel, input int dir, input int cnt);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_load = kind[0]; req_sel = sel[1:0];
        req_dir = dir[0]; req_count = cnt[REP_W-1:0];
        e.kind = kind; e.sel = sel; e.dir = dir;
        e.steps = (kind == 1) ? 0 : ((cnt == 0) ? 1 : cnt);
        e.loads = (kind == 1) ? 1 : 0;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Raises a request mid-operation; it must be ignored (R2).
    task automatic poke_busy();
        @(negedge clk);
        while (!busy) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_load = 1'b1; req_sel = ~pll_sel; req_dir = ~pll_dir;
        req_count = '1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    bit in_op = 0, seen_act = 0, prev_low = 0, prev_load = 0, after_done = 0, sel_moved = 0;
    int setup_n, steps, loads, low_run, load_run, idle_run, sel0, dir0;

    always @(negedge clk) begin
        if (!rst) begin
            if (after_done) begin
                chk(!done && !busy, "R10 done single cycle / busy low", {done, busy}, 0);
                after_done = 0;
            end
            if (busy && !in_op) begin
                in_op = 1; seen_act = 0; setup_n = 0; steps = 0; loads = 0;
                low_run = 0; load_run = 0; idle_run = 0; sel_moved = 0;
                sel0 = pll_sel; dir0 = pll_dir;
            end
            if (in_op) begin
                if (pll_sel != sel0[1:0] || pll_dir != dir0[0]) sel_moved = 1;
                if (!pll_step_n) begin
                    if (!prev_low) begin
                        steps++;
                        if (!seen_act) chk(setup_n == E_SETUP, "R4 setup cycles", setup_n, E_SETUP);
                        else chk(idle_run == E_STEP, "R6 high time between steps", idle_run, E_STEP);
                        seen_act = 1; low_run = 0;
                    end
                    low_run++;
                end else if (prev_low) begin
                    chk(low_run == E_STEP, "R5 step low width", low_run, E_STEP);
                    idle_run = 0;
                end
                if (pll_load) begin
                    if (!prev_load) begin
                        loads++;
                        if (!seen_act) chk(setup_n == E_SETUP, "R4 setup cycles", setup_n, E_SETUP);
                        seen_act = 1; load_run = 0;
                    end
                    load_run++;
                end else if (prev_load) begin
                    chk(load_run == E_LOAD, "R8 load pulse width", load_run, E_LOAD);
                    idle_run = 0;
                end
                if (pll_step_n && !pll_load && !done) begin
                    if (!seen_act) setup_n++;
                    else idle_run++;
                end
                if (done) begin
                    exp_t e;
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected operation", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(sel0 == e.sel && dir0 == e.dir, "R3 select/direction",
                            sel0 * 2 + dir0, e.sel * 2 + e.dir);
                        chk(!sel_moved, "R3 select/direction held", sel_moved, 0);
                        chk(steps == e.steps, "R7 step pulse count", steps, e.steps);
                        chk(loads == e.loads, "R8 load pulse count", loads, e.loads);
                        chk(idle_run == E_STEP + E_SETTLE, "R9 release+settle before done",
                            idle_run, E_STEP + E_SETTLE);
                    end
                    in_op = 0; after_done = 1;
                end
            end
            prev_low  = !pll_step_n;
            prev_load = pll_load;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pll_step_n && !pll_load && !busy && !done, "R1 reset state",
            {pll_step_n, pll_load, busy, done}, 4'b1000);
        rst = 1'b0;
        issue(0, 0, 0, 1);      // single lagging step on main output
        issue(0, 3, 1, 3);      // three leading steps on channel 3
        issue(0, 1, 1, 0);      // count 0 acts as one step (R7)
        issue(1, 2, 0, 5);      // load, count ignored (R8)
        issue(1, 1, 1, 0);      // load, leading
        issue(0, 2, 0, 15);     // long run
        fork
            issue(0, 1, 0, 2);
            poke_busy();
        join
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            chk(!busy && pll_step_n && !pll_load, "R2 ignored request started nothing",
                {busy, pll_step_n, pll_load}, 3'b010);
        end
        issue(0, 3, 0, 2);      // back-to-back after idle (R10)
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(!busy && pll_step_n && !pll_load, "R1 rest after operations",
            {busy, pll_step_n, pll_load}, 3'b010);
        report();
    end
endmodule